// File: doc/BRIEF.md
# UART Receive Queue with Selectable Interrupt Threshold

This block is the receiving half of a serial port. A receive shifter watches the serial line and assembles each frame. A frame is a low start bit, then the data bits least significant first, then an optional even-parity bit, then a high stop bit. The shifter counts an oversampling tick to find the middle of each bit. Each finished word moves into a four-entry queue, together with a framing-error tag and a parity-error tag. Software reads the queue one word at a time through a read strobe.

The block raises a one-cycle interrupt pulse when a word enters the queue. A 2-bit select input chooses when that pulse fires: on every word, when the queue reaches three words, or when it becomes full. If a word completes while the queue is full, the shifter keeps that word, stops taking data from the line and raises a sticky overrun flag. The flag stays set until software clears it.

Top module: `rx_word_fifo`

## Requirements
- R1: The queue holds at most 4 words. A transfer into the queue never happens while 4 words are held.
- R2: `rx_avail` is 1 whenever the queue holds one or more words and 0 when it holds none.
- R3: A read strobe while the queue is empty changes nothing. `rx_data`, `rx_ferr` and `rx_perr` keep showing the word that was popped last (all zero after reset), and the next arriving word is returned normally.
- R4: A read strobe pops the oldest word. Words come out in arrival order. `rx_data`, `rx_ferr` and `rx_perr` always show the oldest held word and its tags. `rx_perr` is 1 when the XOR of the data bits and the parity bit is 1. `rx_ferr` is 1 when the stop bit samples low.
- R5: With `irq_sel` equal to 2'b00 or 2'b01, `rx_irq` pulses for one cycle for every word that enters the queue. The pulse comes in the cycle after the transfer.
- R6: With `irq_sel` equal to 2'b10, `rx_irq` pulses only for a transfer that leaves exactly 3 words in the queue.
- R7: With `irq_sel` equal to 2'b11, `rx_irq` pulses only for a transfer that leaves the queue full (4 words).
- R8: `rx_overrun` rises only when a word's stop bit is sampled while the queue is full. The shifter then holds that fifth word.
- R9: While `rx_overrun` is 1, the shifter takes in no line data. Words already in the queue stay readable in order. The flag stays set through reads.
- R10: A pulse on `ovr_clr` clears `rx_overrun` and discards the held word. Reception starts again at the next start bit.
- R11: Reset empties the queue and clears `rx_overrun` and `rx_irq`.
- R12: A low pulse on the line that is high again at the middle of the start bit is ignored. No word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, already synchronous to clk, idle high |
| baud_tick | input | 1 | Oversampling tick, OSR ticks per bit |
| rd_stb | input | 1 | Pops the oldest word |
| irq_sel | input | 2 | Interrupt threshold select |
| ovr_clr | input | 1 | Clears the overrun flag and the held word |
| rx_data | output | DATA_W | Oldest word's data |
| rx_ferr | output | 1 | Oldest word's framing-error tag |
| rx_perr | output | 1 | Oldest word's parity-error tag |
| rx_avail | output | 1 | Queue not empty |
| rx_irq | output | 1 | Interrupt pulse |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
The checks assume that `rxd` is already synchronous to the clock. They also assume that `irq_sel` holds its value between a transfer and the pulse that follows it, so the threshold check can refer to the select of the previous cycle. The stimulus asserts `baud_tick` on every cycle and holds each serial bit for exactly OSR cycles. It changes `irq_sel` and strobes reads or clears only while the line is idle, so no read ever meets a transfer in the same cycle.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  localparam logic [1:0] SEL_EVERY = 2'b00;
  localparam logic [1:0] SEL_THREE = 2'b10;
  localparam logic [1:0] SEL_FULL  = 2'b11;

  // Decides whether a transfer that leaves `fill` words raises the pulse.
  function automatic logic irq_fire(input logic [1:0] sel, input int fill, input int depth);
    case (sel)
      SEL_THREE: return fill == depth - 1;
      SEL_FULL:  return fill == depth;
      default:   return 1'b1;
    endcase
  endfunction

  // Fill level after a transfer, given the level before and a same-cycle pop.
  function automatic int fill_after(input int fill_now, input logic popped);
    return fill_now + 1 - (popped ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxq_shifter.sv
module rxq_shifter
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter bit PAR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              fifo_full,
  input  logic              ovr_clr,
  output logic              push,
  output logic [DATA_W-1:0] word_data,
  output logic              word_ferr,
  output logic              word_perr,
  output logic              overrun
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int HALF  = OSR / 2;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bidx;
  logic [DATA_W-1:0] shreg;
  logic              pbit;

  function automatic logic par_bad(input logic [DATA_W-1:0] d, input logic p);
    return PAR_EN && ((^d) ^ p);
  endfunction

  wire bit_end   = tick && (cnt == CNT_W'(OSR - 1));
  wire start_mid = tick && (cnt == CNT_W'(HALF - 1));
  wire stop_evt  = (state == RX_STOP) && bit_end;

  assign push      = stop_evt && !fifo_full;
  assign word_data = shreg;
  assign word_ferr = !rxd;
  assign word_perr = par_bad(shreg, pbit);
  assign overrun   = (state == RX_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      cnt   <= '0;
      bidx  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (tick && !rxd) begin
            state <= RX_START;
            cnt   <= '0;
          end
        end
        RX_START: begin
          if (start_mid) begin
            state <= rxd ? RX_IDLE : RX_DATA;
            cnt   <= '0;
            bidx  <= '0;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt   <= '0;
            shreg <= {rxd, shreg[DATA_W-1:1]};
            if (bidx == BIT_W'(DATA_W - 1)) state <= PAR_EN ? RX_PAR : RX_STOP;
            else bidx <= bidx + 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_PAR: begin
          if (bit_end) begin
            cnt   <= '0;
            pbit  <= rxd;
            state <= RX_STOP;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt   <= '0;
            state <= fifo_full ? RX_HOLD : RX_IDLE;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        RX_HOLD: begin
          if (ovr_clr) begin
            state <= RX_IDLE;
            shreg <= '0;
            pbit  <= 1'b0;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // R8
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fifo_full));

  // R9
  frozen_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> ($stable(shreg) && overrun));

  // R10
  ovr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && ovr_clr) |=> !overrun);

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               wr_word,
  input  logic                       pop_req,
  output logic                       pop_fire,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;
  logic [W-1:0]  stale_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign pop_fire = pop_req && (count_q != '0);
  assign full     = (count_q == CW'(DEPTH));
  assign count    = count_q;
  assign head     = (count_q == '0) ? stale_q : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
      stale_q <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_fire) begin
        rd_ptr  <= ptr_inc(rd_ptr);
        stale_q <= mem[rd_ptr];
      end
      case ({push, pop_fire})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CW'(DEPTH)));

  // R2
  push_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (count_q != '0));

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count_q == '0 && !push) |=> ($stable(head) && count_q == '0));

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop_fire,
  input  logic [$clog2(DEPTH+1)-1:0] count,
  input  logic [1:0]                 sel,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH + 1);

  wire hit = push && irq_fire(sel, fill_after(int'(count), pop_fire), DEPTH);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= hit;
  end

  // R5
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(push));

  // R6
  three_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(sel) == SEL_THREE) |-> (count == CW'(DEPTH - 1)));

  // R7
  full_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && $past(sel) == SEL_FULL) |-> (count == CW'(DEPTH)));

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int OSR    = 16,
  parameter bit PAR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              baud_tick,
  input  logic              rd_stb,
  input  logic [1:0]        irq_sel,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ferr,
  output logic              rx_perr,
  output logic              rx_avail,
  output logic              rx_irq,
  output logic              rx_overrun
);
  localparam int W  = DATA_W + 2;
  localparam int CW = $clog2(DEPTH + 1);

  logic              push, pop_fire, full;
  logic [DATA_W-1:0] w_data;
  logic              w_ferr, w_perr;
  logic [W-1:0]      head;
  logic [CW-1:0]     count;

  rxq_shifter #(.DATA_W(DATA_W), .OSR(OSR), .PAR_EN(PAR_EN)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
    .fifo_full(full), .ovr_clr(ovr_clr), .push(push),
    .word_data(w_data), .word_ferr(w_ferr), .word_perr(w_perr),
    .overrun(rx_overrun)
  );

  rxq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push),
    .wr_word({w_perr, w_ferr, w_data}), .pop_req(rd_stb),
    .pop_fire(pop_fire), .head(head), .count(count), .full(full)
  );

  rxq_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst_n(rst_n), .push(push), .pop_fire(pop_fire),
    .count(count), .sel(irq_sel), .irq(rx_irq)
  );

  assign rx_data  = head[DATA_W-1:0];
  assign rx_ferr  = head[DATA_W];
  assign rx_perr  = head[DATA_W+1];
  assign rx_avail = (count != '0);

  // R11
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> (!rx_avail && !rx_overrun && !rx_irq));

endmodule

// File: tb/rx_word_fifo_test.sv
module rx_word_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       baud_tick = 1'b1;
  logic       rd_stb = 1'b0;
  logic [1:0] irq_sel = 2'b00;
  logic       ovr_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ferr, rx_perr, rx_avail, rx_irq, rx_overrun;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  int base;

  always #10 clk = ~clk;

  rx_word_fifo uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
    .rd_stb(rd_stb), .irq_sel(irq_sel), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .rx_avail(rx_avail), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  always @(negedge clk) if (rx_irq === 1'b1) irq_cnt++;

  // vector: data, corrupt parity, corrupt stop
  localparam logic [9:0] VEC [6] = '{
    {8'hA5, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b0}, {8'h00, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1}, {8'h81, 1'b0, 1'b0}, {8'h7E, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic bp, input logic bs);
    logic [10:0] bits;
    bits = {~bs, (^d) ^ bp, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      repeat (16) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  task automatic pop();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R11 reset state
    check("R11 avail", rx_avail, 0);
    check("R11 overrun", rx_overrun, 0);
    check("R11 irq", rx_irq, 0);
    check("R3 head after reset", rx_data, 0);

    // table walk: sel alternates 00/01
    for (int i = 0; i < 6; i++) begin
      irq_sel = {1'b0, i[0]};
      base = irq_cnt;
      send(VEC[i][9:2], VEC[i][1], VEC[i][0]);
      check("R2 avail set", rx_avail, 1);
      check("R4 data", rx_data, VEC[i][9:2]);
      check("R4 perr", rx_perr, VEC[i][1]);
      check("R4 ferr", rx_ferr, VEC[i][0]);
      check("R5 irq every word", irq_cnt - base, 1);
      pop();
      check("R2 avail clear", rx_avail, 0);
      check("R3 stale head", rx_data, VEC[i][9:2]);
    end

    // R3 read of empty queue
    pop();
    check("R3 empty read data", rx_data, 8'h7E);
    check("R3 empty read avail", rx_avail, 0);
    send(8'h5C, 1'b0, 1'b0);
    check("R3 next word after empty read", rx_data, 8'h5C);
    pop();

    // R4 ordering
    irq_sel = 2'b00;
    send(8'h11, 0, 0); send(8'h22, 0, 0); send(8'h33, 0, 0);
    check("R4 first", rx_data, 8'h11); pop();
    check("R4 second", rx_data, 8'h22); pop();
    check("R4 third", rx_data, 8'h33); pop();
    check("R2 drained", rx_avail, 0);

    // R6 threshold three, then overrun
    irq_sel = 2'b10;
    base = irq_cnt;
    send(8'h41, 0, 0); send(8'h42, 0, 0);
    check("R6 no pulse below three", irq_cnt - base, 0);
    send(8'h43, 0, 0);
    check("R6 pulse at three", irq_cnt - base, 1);
    send(8'h44, 0, 0);
    check("R6 no pulse at four", irq_cnt - base, 1);
    check("R8 no overrun when just full", rx_overrun, 0);
    send(8'h45, 0, 0);
    check("R8 overrun on fifth word", rx_overrun, 1);
    check("R1 no pulse on held word", irq_cnt - base, 1);
    send(8'h46, 0, 0);
    check("R9 queue kept first", rx_data, 8'h41); pop();
    check("R9 queue kept second", rx_data, 8'h42); pop();
    check("R9 queue kept third", rx_data, 8'h43); pop();
    check("R9 queue kept fourth", rx_data, 8'h44); pop();
    check("R1 only four queued", rx_avail, 0);
    check("R9 overrun sticky", rx_overrun, 1);
    send(8'h47, 0, 0);
    check("R9 no intake while overrun", rx_avail, 0);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    check("R10 overrun cleared", rx_overrun, 0);
    check("R10 held word discarded", rx_avail, 0);
    send(8'h48, 0, 0);
    check("R10 reception restarts", rx_data, 8'h48);
    pop();

    // R7 threshold full
    irq_sel = 2'b11;
    base = irq_cnt;
    send(8'h51, 0, 0); send(8'h52, 0, 0); send(8'h53, 0, 0);
    check("R7 no pulse below full", irq_cnt - base, 0);
    send(8'h54, 0, 0);
    check("R7 pulse at full", irq_cnt - base, 1);

    // R11 reset empties a full queue
    do_reset();
    check("R11 reset empties", rx_avail, 0);
    check("R11 reset head", rx_data, 0);

    // R12 glitch rejected
    irq_sel = 2'b00;
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (60) @(negedge clk);
    check("R12 glitch ignored", rx_avail, 0);
    send(8'h5A, 0, 0);
    check("R12 normal word after glitch", rx_data, 8'h5A);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule